// File: doc/BRIEF.md
# Vector length configuration unit

This block works out how many vector elements a machine can hold under its present register configuration, then answers set-length requests from software with the granted length. A configuration names which register banks are switched on (an 8-bit enable mask taken from a wider written word), how many registers each bank holds, and how many integer and floating-point registers each element needs. The unit counts the enabled banks and divides the per-bank register count by the per-element demand. It scales the quotient by the bank count and caps the result at the hardware thread limit. The capped value is the maximum vector length.

A pulse on `cfg_start` begins a configuration. A restoring shift-subtract divider produces one quotient bit per cycle. When the maximum length has settled, `cfg_done` pulses for one cycle. A set-length request (`req_valid` with `req_len`) is granted the smaller of the request and the maximum length. A request that arrives before any configuration has completed, or while one is in progress, is kept and answered once the new maximum is ready. A `cfg_start` that arrives while a configuration is still running is ignored.

Top module: `vlen_cfg_unit`

## Requirements
- R1: Only bits [7:0] of `bank_wdata` form the bank-enable mask, and the upper bits have no effect. The number of enabled banks is the count of ones in that mask.
- R2: When `int_used + fp_used` is 0 or 1, the maximum length is `regs_per_bank` times the enabled bank count, before the cap.
- R3: When `int_used + fp_used` is 2 or more, the maximum length is floor(`regs_per_bank` / (`int_used + fp_used - 1`)) times the enabled bank count, before the cap.
- R4: `max_len` never exceeds MAX_THREADS (32 by default). A larger product is reported as MAX_THREADS.
- R5: A request sampled while a configuration is valid raises `grant_valid` for one cycle after that edge, with `grant_len` = min(`req_len`, `max_len`).
- R6: A request sampled while no configuration is valid is held and not granted early. Only the most recent held request is kept. It is granted, clamped against the new maximum, in the cycle after `cfg_done`.
- R7: `cfg_done` is a one-cycle pulse that appears REGS_W+1 cycles (9 by default) after the edge that accepts `cfg_start`. `max_len` changes only in a cycle where `cfg_done` is high.
- R8: With an all-zero bank mask, `max_len` is 0 and every grant is 0.
- R9: After reset, `max_len`, `grant_len`, `cfg_done` and `grant_valid` are 0, and no configuration is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start a configuration; ignored while one is running |
| bank_wdata | input | WDATA_W (32) | Written word; low MASK_W bits are the bank-enable mask |
| regs_per_bank | input | REGS_W (8) | Registers in each bank |
| int_used | input | USE_W (4) | Integer registers used per element |
| fp_used | input | USE_W (4) | Floating-point registers used per element |
| req_valid | input | 1 | Set-length request strobe |
| req_len | input | REQ_W (12) | Requested application vector length |
| max_len | output | LEN_W (6) | Maximum vector length |
| cfg_done | output | 1 | One-cycle pulse when max_len is updated |
| grant_valid | output | 1 | Granted length is valid this cycle |
| grant_len | output | LEN_W (6) | Granted vector length |

## Verification
The bench sweeps every bank mask with random-looking upper bits in the written word. This catches a design that counts too many bits or lets the upper bits reach the count. It crosses many register counts with every usage sum from 0 up to 7, plus the largest sum. That covers the step between the undivided and divided formulas: an off-by-one divisor would halve or double the length at that step. It also covers products far above the thread cap, where a truncating design would wrap rather than saturate. Requests at zero, at exactly the maximum, one above it and at full scale test the minimum selection. Requests made before the first configuration and during a running one test holding, last-wins replacement and the one-cycle grant latency after `cfg_done`. A design that granted early or lost the held request would show up here.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vcfg_state_e;
endpackage

// File: rtl/vlen_popcount.sv
module vlen_popcount #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/vlen_divider.sv
module vlen_divider #(
  parameter int NUM_W = 8,
  parameter int DEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   diff;
  logic             fits;

  always_comb begin
    shifted = {rem, quot[NUM_W-1]};
    diff    = shifted - {1'b0, den_q};
    fits    = (shifted >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      quot  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        quot  <= numer;
        rem   <= '0;
        den_q <= denom;
        cnt   <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        quot <= {quot[NUM_W-2:0], fits};
        rem  <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        cnt  <= cnt + 1'b1;
        if (cnt == CNT_W'(NUM_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vlen_grant.sv
module vlen_grant #(
  parameter int REQ_W = 12,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_len,
  input  logic [LEN_W-1:0] max_len,
  output logic             grant_valid,
  output logic [LEN_W-1:0] grant_len
);
  localparam int MW = (REQ_W > LEN_W) ? REQ_W : LEN_W;

  logic             pend;
  logic [REQ_W-1:0] pend_len;
  logic [REQ_W-1:0] sel_len;
  logic             fire;

  always_comb begin
    sel_len = req_valid ? req_len : pend_len;
    fire    = ready && (req_valid || pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      pend_len    <= '0;
      grant_valid <= 1'b0;
      grant_len   <= '0;
    end else begin
      grant_valid <= fire;
      if (fire) begin
        pend <= 1'b0;
        if (MW'(sel_len) < MW'(max_len)) grant_len <= LEN_W'(sel_len);
        else                             grant_len <= max_len;
      end else if (req_valid) begin
        pend     <= 1'b1;
        pend_len <= req_len;
      end
    end
  end
endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit #(
  parameter int MASK_W      = 8,
  parameter int WDATA_W     = 32,
  parameter int REGS_W      = 8,
  parameter int USE_W       = 4,
  parameter int MAX_THREADS = 32,
  parameter int REQ_W       = 12,
  parameter int LEN_W       = $clog2(MAX_THREADS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_start,
  input  logic [WDATA_W-1:0] bank_wdata,
  input  logic [REGS_W-1:0]  regs_per_bank,
  input  logic [USE_W-1:0]   int_used,
  input  logic [USE_W-1:0]   fp_used,
  input  logic               req_valid,
  input  logic [REQ_W-1:0]   req_len,
  output logic [LEN_W-1:0]   max_len,
  output logic               cfg_done,
  output logic               grant_valid,
  output logic [LEN_W-1:0]   grant_len
);
  import vlen_pkg::*;

  localparam int BC_W   = $clog2(MASK_W + 1);
  localparam int SUM_W  = USE_W + 1;
  localparam int PROD_W = REGS_W + BC_W;
  localparam int CMP_W  = (PROD_W > 32) ? PROD_W : 32;

  vcfg_state_e       state;
  logic              cfg_ok;
  logic [MASK_W-1:0] mask_q;
  logic [BC_W-1:0]   bank_cnt;
  logic [SUM_W-1:0]  use_sum;
  logic [SUM_W-1:0]  divisor;
  logic              accept;
  logic              div_busy;
  logic              div_done;
  logic [REGS_W-1:0] quot;
  logic [PROD_W-1:0] product;
  logic [LEN_W-1:0]  capped;

  always_comb begin
    use_sum = SUM_W'(int_used) + SUM_W'(fp_used);
    divisor = (use_sum < SUM_W'(2)) ? SUM_W'(1) : use_sum - SUM_W'(1);
    accept  = cfg_start && (state == ST_IDLE) && !div_busy;
    product = PROD_W'(quot) * PROD_W'(bank_cnt);
    capped  = (CMP_W'(product) > CMP_W'(MAX_THREADS)) ? LEN_W'(MAX_THREADS)
                                                       : LEN_W'(product);
  end

  vlen_popcount #(.W(MASK_W), .CW(BC_W)) u_pop (
    .bits  (mask_q),
    .count (bank_cnt)
  );

  vlen_divider #(.NUM_W(REGS_W), .DEN_W(SUM_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .numer (regs_per_bank),
    .denom (divisor),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cfg_ok   <= 1'b0;
      mask_q   <= '0;
      max_len  <= '0;
      cfg_done <= 1'b0;
    end else begin
      cfg_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            mask_q <= bank_wdata[MASK_W-1:0];
            cfg_ok <= 1'b0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (div_done) begin
            max_len  <= capped;
            cfg_done <= 1'b1;
            cfg_ok   <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  vlen_grant #(.REQ_W(REQ_W), .LEN_W(LEN_W)) u_grant (
    .clk         (clk),
    .rst         (rst),
    .ready       (cfg_ok),
    .req_valid   (req_valid),
    .req_len     (req_len),
    .max_len     (max_len),
    .grant_valid (grant_valid),
    .grant_len   (grant_len)
  );
endmodule

// File: rtl/vlen_cfg_checker.sv
module vlen_cfg_checker #(
  parameter int MAX_THREADS = 32,
  parameter int LEN_W       = $clog2(MAX_THREADS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_done,
  input logic             cfg_ok,
  input logic [LEN_W-1:0] max_len,
  input logic             grant_valid,
  input logic [LEN_W-1:0] grant_len
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> !cfg_done); // R7
  AST_MAX_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |-> $stable(max_len)); // R7
  AST_MAX_CAP: assert property (@(posedge clk) disable iff (rst)
    32'(max_len) <= MAX_THREADS); // R4
  AST_GRANT_LE_MAX: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant_len <= max_len); // R5
  AST_GRANT_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> $past(cfg_ok)); // R6
endmodule

bind vlen_cfg_unit vlen_cfg_checker #(.MAX_THREADS(MAX_THREADS), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_done    (cfg_done),
  .cfg_ok      (cfg_ok),
  .max_len     (max_len),
  .grant_valid (grant_valid),
  .grant_len   (grant_len)
);

// File: tb/tb_vlen_cfg_unit.sv
module tb_vlen_cfg_unit;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_start = 1'b0;
  logic [31:0]      bank_wdata = '0;
  logic [7:0]       regs_per_bank = '0;
  logic [3:0]       int_used = '0;
  logic [3:0]       fp_used = '0;
  logic             req_valid = 1'b0;
  logic [11:0]      req_len = '0;
  logic [LEN_W-1:0] max_len;
  logic             cfg_done;
  logic             grant_valid;
  logic [LEN_W-1:0] grant_len;

  int checks = 0;
  int failures = 0;
  bit early = 0;

  always #5 clk = ~clk;

  vlen_cfg_unit dut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .bank_wdata(bank_wdata),
    .regs_per_bank(regs_per_bank), .int_used(int_used), .fp_used(fp_used),
    .req_valid(req_valid), .req_len(req_len), .max_len(max_len),
    .cfg_done(cfg_done), .grant_valid(grant_valid), .grant_len(grant_len)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_max(input int mask, input int regs, input int iu, input int fu);
    int pc = 0;
    int q;
    int m;
    for (int i = 0; i < 8; i++) pc += (mask >> i) & 1;
    q = (iu + fu < 2) ? regs : regs / (iu + fu - 1);
    m = q * pc;
    if (m > 32) m = 32;
    return m;
  endfunction

  task automatic launch(input logic [31:0] wd, input int regs, input int iu, input int fu);
    @(negedge clk);
    bank_wdata = wd; regs_per_bank = 8'(regs); int_used = 4'(iu); fp_used = 4'(fu);
    cfg_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic finish_cfg(input logic [31:0] wd, input int regs, input int iu,
                            input int fu, input int n0, input string tag);
    int n = n0;
    while (!cfg_done && n < 100) begin
      if (grant_valid) early = 1;
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk({tag, " R7 done latency"}, n, 9);
    chk({tag, " max_len"}, int'(max_len), exp_max(int'(wd[7:0]), regs, iu, fu));
    @(posedge clk);
    @(negedge clk);
    chk("R7 done is a single pulse", int'(cfg_done), 0);
  endtask

  task automatic configure(input logic [31:0] wd, input int regs, input int iu,
                           input int fu, input string tag);
    launch(wd, regs, iu, fu);
    finish_cfg(wd, regs, iu, fu, 0, tag);
  endtask

  task automatic request(input int len, input string tag);
    int e;
    @(negedge clk);
    req_valid = 1'b1; req_len = 12'(len);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e = (len < int'(max_len)) ? len : int'(max_len);
    chk({tag, " grant_valid"}, int'(grant_valid), 1);
    chk({tag, " grant_len"}, int'(grant_len), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int regs_list[12] = '{0, 1, 2, 3, 7, 8, 31, 32, 63, 100, 200, 255};
    logic [7:0] masks[3] = '{8'hA5, 8'h01, 8'hFF};
    int e;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9 reset state
    chk("R9 max_len after reset", int'(max_len), 0);
    chk("R9 cfg_done after reset", int'(cfg_done), 0);
    chk("R9 grant_valid after reset", int'(grant_valid), 0);
    chk("R9 grant_len after reset", int'(grant_len), 0);

    // R9/R6: request before any configuration is held
    @(negedge clk); req_valid = 1'b1; req_len = 12'd20;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    repeat (4) begin
      chk("R6 no grant before first configuration", int'(grant_valid), 0);
      @(negedge clk);
    end
    early = 0;
    configure(32'h0000_000F, 16, 1, 1, "R4 capped 64->32");
    chk("R6 held request granted after done", int'(grant_valid), 1);
    chk("R6 held request length", int'(grant_len), 20);
    chk("R6 no grant before done", int'(early), 0);

    // R6: requests during a running configuration, last one wins
    launch(32'h0000_0003, 10, 2, 2);
    req_valid = 1'b1; req_len = 12'd100;
    @(posedge clk); @(negedge clk);
    req_len = 12'd5;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    early = 0;
    finish_cfg(32'h0000_0003, 10, 2, 2, 2, "R3 divided by 3");
    chk("R6 latest held request granted", int'(grant_valid), 1);
    chk("R6 latest held request length", int'(grant_len), 5);
    chk("R6 no grant while running", int'(early), 0);

    // R8: no banks enabled
    configure(32'hFFFF_FF00, 200, 0, 0, "R8 zero mask");
    chk("R8 max_len zero", int'(max_len), 0);
    request(7, "R8 zero grant");
    request(0, "R8 zero request");

    // R1: sweep every mask with noisy upper bits, per-element sum 3 -> divisor 2
    for (int m = 0; m < 256; m++) begin
      logic [31:0] wd;
      wd = {8'(m * 37 + 11), 8'(~m), 8'(m ^ 8'h5A), 8'(m)};
      configure(wd, 9, 2, 1, "R1 mask sweep");
      request(m % 40, "R5 mask sweep request");
    end

    // R2/R3/R4/R5: registers x usage sums x masks
    foreach (regs_list[r]) begin
      for (int iu = 0; iu < 5; iu++) begin
        for (int fu = 0; fu < 4; fu++) begin
          foreach (masks[k]) begin
            configure({24'hC3C3C3, masks[k]}, regs_list[r], iu, fu,
                      (iu + fu < 2) ? "R2 undivided" : "R3 divided");
            e = int'(max_len);
            request(0, "R5 zero request");
            request(e, "R5 request equal to max");
            request(e + 1, "R5 request above max");
            request(4095, "R5 full scale request");
          end
        end
      end
    end

    // R3: largest usage sum, divisor 29
    configure(32'h0000_00FF, 255, 15, 15, "R3 largest divisor");
    configure(32'h0000_00FF, 28, 15, 15, "R3 quotient zero");
    request(9, "R5 grant with zero max");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule